// File: doc/BRIEF.md
# Memory Controller Clock-Stop Sequencer

This block is the power-down control of a DRAM controller. Software raises a stop request. From then on the sequencer refuses new memory requests at the controller's request handshake and waits for the command queue to empty. The queue reports a count of pending transactions and a flag for a command in flight. When nothing is left, the sequencer parks. While parked, it drops the clock enable of the controller core and withholds every refresh command.

The sequence runs one way only. Once the stop request has been seen, lowering it again changes nothing. Only a synchronous reset brings the controller back to normal service.

Software must shut the address window to the memory before it requests the stop. A request that arrives while the sequencer is parked is never granted, so the requester would otherwise wait forever.

Top module: `clkstop_seq`

## Requirements
- R1: After reset, `mode` is 0 (run), `req_ready` is 1, `core_clk_en` is 1, `refresh_cmd` is 0 and `stopped` is 0.
- R2: In run, a clock edge that samples `stop_req` high moves `mode` to 1 (drain) at that edge. With `stop_req` low, the block stays in run.
- R3: `req_ready` is 1 while in run. It is 0 from the first drain cycle onward and stays 0 while parked.
- R4: In run and in drain, an edge that samples `refresh_tick` high makes `refresh_cmd` high for exactly the following cycle.
- R5: Drain moves to `mode` 2 (parked) at the edge that samples all three of these conditions: `pend_cnt` equal to zero, `inflight` low and `refresh_tick` low. At any other edge the block stays in drain. A tick that arrives while draining is therefore always issued before parking.
- R6: While parked, `refresh_cmd` stays 0 whatever `refresh_tick` does.
- R7: `stopped` is 1 exactly when `mode` is 2. `core_clk_en` stays 1 during the first parked cycle. It is 0 from the second parked cycle until reset.
- R8: In drain and while parked, lowering `stop_req` has no effect. Only `rst` returns the block to run.
- R9: `req_take` is high exactly when `req_valid` and `req_ready` are both high, so it can be high only in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Software stop request |
| pend_cnt | input | CNT_W | Transactions still queued toward memory |
| inflight | input | 1 | A command is currently being executed |
| req_valid | input | 1 | New memory request offered |
| req_ready | output | 1 | New requests may be accepted |
| req_take | output | 1 | Request accepted in this cycle |
| refresh_tick | input | 1 | Refresh interval elapsed |
| refresh_cmd | output | 1 | Refresh command toward memory |
| core_clk_en | output | 1 | Clock enable for the controller core |
| stopped | output | 1 | Block is parked |
| mode | output | 2 | 0 run, 1 drain, 2 parked |

## Verification
The assertions check the following on every cycle:
- no ready and no grant outside run;
- no refresh while parked;
- parking is permanent;
- a busy queue holds off parking;
- the clock enable lags the parked state by one cycle;
- every allowed tick yields a command.

Only the bench scenarios can show three things. First, the exact edge of each transition as the pending count drains from different starting values. Second, a tick that coincides with an otherwise idle queue delays parking by one cycle. Third, lowering the stop request and then resetting returns the block to run.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    CSQ_RUN    = 2'd0,
    CSQ_DRAIN  = 2'd1,
    CSQ_PARKED = 2'd2
  } csq_state_e;
endpackage

// File: rtl/csq_idle_detect.sv
module csq_idle_detect #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             inflight,
  input  logic             refresh_tick,
  output logic             quiet
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Parking is allowed only with an empty queue, no command on the bus
  // and no refresh waiting to be issued.
  always_comb quiet = (pend_cnt == ZERO) && !inflight && !refresh_tick;
endmodule

// File: rtl/csq_refresh_gate.sv
module csq_refresh_gate (
  input  logic clk,
  input  logic rst,
  input  logic refresh_tick,
  input  logic allow,
  output logic refresh_cmd
);
  always_ff @(posedge clk) begin
    if (rst) refresh_cmd <= 1'b0;
    else     refresh_cmd <= refresh_tick && allow;
  end

  AST_TICK_SERVED: assert property (@(posedge clk) disable iff (rst)
    (refresh_tick && allow) |=> refresh_cmd); // R4
  AST_NO_UNASKED_CMD: assert property (@(posedge clk) disable iff (rst)
    !refresh_tick |=> !refresh_cmd); // R4
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic [CNT_W-1:0] pend_cnt,
  input  logic             inflight,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             req_take,
  input  logic             refresh_tick,
  output logic             refresh_cmd,
  output logic             core_clk_en,
  output logic             stopped,
  output logic [1:0]       mode
);
  import csq_pkg::*;

  csq_state_e st_q, st_d;
  logic       quiet;
  logic       ready_q;
  logic       clken_q;

  csq_idle_detect #(.CNT_W(CNT_W)) u_idle (
    .pend_cnt     (pend_cnt),
    .inflight     (inflight),
    .refresh_tick (refresh_tick),
    .quiet        (quiet)
  );

  csq_refresh_gate u_rgate (
    .clk          (clk),
    .rst          (rst),
    .refresh_tick (refresh_tick),
    .allow        (st_q != CSQ_PARKED),
    .refresh_cmd  (refresh_cmd)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      CSQ_RUN:    if (stop_req) st_d = CSQ_DRAIN;
      CSQ_DRAIN:  if (quiet)    st_d = CSQ_PARKED;
      CSQ_PARKED: st_d = CSQ_PARKED;
      default:    st_d = CSQ_PARKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CSQ_RUN;
      ready_q <= 1'b1;
      clken_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      ready_q <= (st_d == CSQ_RUN);
      clken_q <= (st_q != CSQ_PARKED);
    end
  end

  assign req_ready   = ready_q;
  assign req_take    = req_valid && ready_q;
  assign core_clk_en = clken_q;
  assign stopped     = (st_q == CSQ_PARKED);
  assign mode        = st_q;

  AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    (st_q != CSQ_RUN) |-> !req_ready); // R3
  AST_TAKE_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    req_take |-> (st_q == CSQ_RUN)); // R9
  AST_PARKED_NO_REFRESH: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !refresh_cmd); // R6
  AST_PARK_STICKY: assert property (@(posedge clk) disable iff (rst)
    stopped |=> stopped); // R8
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((st_q == CSQ_DRAIN) && (inflight || pend_cnt != '0)) |=> (st_q == CSQ_DRAIN)); // R5
  AST_CLKEN_LAG: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (core_clk_en == !$past(stopped))); // R7
  AST_NO_SKIP_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (st_q == CSQ_RUN) |=> (st_q != CSQ_PARKED)); // R2
endmodule

// File: tb/test_clkstop_seq.sv
module test_clkstop_seq;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stop_req = 1'b0;
  logic [CNT_W-1:0] pend_cnt = '0;
  logic             inflight = 1'b0;
  logic             req_valid = 1'b0;
  logic             refresh_tick = 1'b0;
  logic             req_ready, req_take, refresh_cmd, core_clk_en, stopped;
  logic [1:0]       mode;

  int n_chk = 0;
  int n_bad = 0;

  // expected state, 0 run, 1 drain, 2 parked
  int e_st = 0;
  bit e_ready = 1'b1, e_cmd = 1'b0, e_clken = 1'b1;

  always #4 clk = ~clk;

  clkstop_seq #(.CNT_W(CNT_W)) i_clkstop_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .pend_cnt(pend_cnt),
    .inflight(inflight), .req_valid(req_valid), .req_ready(req_ready),
    .req_take(req_take), .refresh_tick(refresh_tick), .refresh_cmd(refresh_cmd),
    .core_clk_en(core_clk_en), .stopped(stopped), .mode(mode)
  );

  // Reference built from the requirement list.
  always @(posedge clk) begin
    int nxt;
    if (rst) begin
      e_st = 0; e_ready = 1'b1; e_cmd = 1'b0; e_clken = 1'b1;
    end else begin
      nxt = e_st;
      if (e_st == 0 && stop_req) nxt = 1;                                          // R2
      if (e_st == 1 && pend_cnt == 0 && !inflight && !refresh_tick) nxt = 2;       // R5
      e_cmd   = refresh_tick && (e_st != 2);                                       // R4 R6
      e_clken = (e_st != 2);                                                       // R7
      e_ready = (nxt == 0);                                                        // R3
      e_st    = nxt;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(mode == 2'(e_st), "R2/R5 mode", int'(mode), e_st);
    chk(req_ready == e_ready, "R3 req_ready", int'(req_ready), int'(e_ready));
    chk(refresh_cmd == e_cmd, "R4/R6 refresh_cmd", int'(refresh_cmd), int'(e_cmd));
    chk(core_clk_en == e_clken, "R7 core_clk_en", int'(core_clk_en), int'(e_clken));
    chk(stopped == (e_st == 2), "R7 stopped", int'(stopped), int'(e_st == 2));
    chk(req_take == (req_valid && e_ready), "R9 req_take", int'(req_take),
        int'(req_valid && e_ready));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; stop_req = 1'b0; pend_cnt = '0; inflight = 1'b0;
    refresh_tick = 1'b0; req_valid = 1'b0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(mode == 2'd0 && req_ready && core_clk_en && !refresh_cmd && !stopped,
        "R1 reset state", int'(mode), 0);
  endtask

  initial begin
    @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      for (int toff = 0; toff < 4; toff++) begin
        for (int il = 0; il < 2; il++) begin
          int dc;
          do_reset();
          // run with ticks and requests
          for (int k = 0; k < 3; k++) begin
            refresh_tick = (k == (n % 3));
            req_valid = k[0];
            pend_cnt = CNT_W'(k);
            cyc();
          end
          // request stop, drain from n
          stop_req = 1'b1;
          pend_cnt = CNT_W'(n);
          refresh_tick = 1'b0;
          cyc();
          chk(mode == 2'd1, "R2 entered drain", int'(mode), 1);
          chk(!req_ready, "R3 ready low in drain", int'(req_ready), 0);
          dc = 0;
          while (mode != 2'd2 && dc < 30) begin
            stop_req = (dc < 2);             // R8 dropping stop has no effect
            req_valid = ~req_valid;
            refresh_tick = (dc == toff);
            if (pend_cnt != 0) pend_cnt = pend_cnt - 1'b1;
            inflight = (pend_cnt == 0) && (dc < n + il) && (il != 0);
            cyc();
            dc++;
          end
          chk(mode == 2'd2, "R5 reached parked", int'(mode), 2);
          // parked: ticks every cycle, stop dropped, requests offered
          for (int k = 0; k < 6; k++) begin
            refresh_tick = 1'b1;
            stop_req = (k < 3);
            req_valid = 1'b1;
            cyc();
            chk(!refresh_cmd, "R6 no refresh parked", int'(refresh_cmd), 0);
            chk(mode == 2'd2, "R8 stays parked", int'(mode), 2);
          end
          chk(!core_clk_en, "R7 clock disabled", int'(core_clk_en), 0);
        end
      end
    end
    // directed: tick coinciding with idle queue delays parking one cycle
    do_reset();
    stop_req = 1'b1; cyc();
    stop_req = 1'b0; refresh_tick = 1'b1; cyc();
    chk(mode == 2'd1, "R5 tick blocks parking", int'(mode), 1);
    refresh_tick = 1'b0; cyc();
    chk(mode == 2'd2, "R5 parks after tick", int'(mode), 2);
    chk(core_clk_en, "R7 first parked cycle enabled", int'(core_clk_en), 1);
    cyc();
    chk(!core_clk_en, "R7 second parked cycle disabled", int'(core_clk_en), 0);
    do_reset();
    chk(mode == 2'd0, "R8 reset exits parked", int'(mode), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule